// File: doc/BRIEF.md
# Memory Ordering Issue Controller

This block sits between a core that produces memory operations strictly in program order and a memory system that can finish those operations out of order and after a variable delay. Each operation arrives as a token: load, store, full fence, acquire or release. The block decides in the same cycle whether the token can be accepted. Loads, stores, acquires and releases accepted this way go straight to memory with a tag. A full fence never goes to memory and is retired inside the block.

The memory system returns tagged completions. The block keeps one outstanding bit per tag and holds back acceptance according to the ordering mode on `mode_i`. Sequential mode allows one operation in flight at a time. Weak mode lets data operations stream up to the tag limit and stops only at fences. Release mode treats an acquire as a barrier that holds back later accesses, and a release as a barrier that waits for earlier accesses. The upstream side sees `op_ready_o` fall whenever a token has to wait.

Top module: `mem_order_issue`

## Requirements
- R1: After reset, nothing is outstanding. `busy_o`, `iss_valid_o` and `fence_retire_o` are low. A load offered in weak mode is accepted at once and gets tag 0.
- R2: With `mode_i`=0 (sequential), a token of any kind is accepted only when no operation is outstanding. A second load waits until the completion of the first has been received.
- R3: With `mode_i`=1 (weak), loads (`op_kind_i`=0) and stores (`op_kind_i`=1) issue in consecutive cycles without waiting for completions, up to 8 outstanding. The ninth waits until a completion frees a tag. An issued tag is never one that is still outstanding.
- R4: A fence (`op_kind_i`=2) is accepted even when operations are outstanding. After that, no token is accepted while the fence is pending. `fence_retire_o` is high for exactly one cycle: the first cycle in which nothing is outstanding. When nothing is outstanding at acceptance, this is the cycle right after the accepting edge. The next token can be accepted in the cycle after retirement.
- R5: `busy_o` is high while one of these holds: a fence is pending, a barrier acquire or release is outstanding, or a release (`op_kind_i`=4) is offered while operations are outstanding.
- R6: With `mode_i`=2 (release), an acquire (`op_kind_i`=3) issues without waiting for earlier operations. No later token is accepted until the completion carrying the acquire's tag has been received.
- R7: In release mode, a release is accepted only when nothing is outstanding. Later loads and stores issue while the release is still outstanding.
- R8: In weak mode, acquire and release each act as a full barrier. Each issues only when nothing is outstanding, and no later token is accepted until it completes.
- R9: Each issued operation takes the lowest-numbered free tag. A completion whose tag is not outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Ordering mode: 0 sequential, 1 weak, 2 release (3 behaves as sequential) |
| op_valid_i | input | 1 | A token is offered |
| op_kind_i | input | 3 | Token kind: 0 load, 1 store, 2 fence, 3 acquire, 4 release |
| op_ready_o | output | 1 | Token is accepted at the next rising edge |
| iss_valid_o | output | 1 | Operation issued to memory this cycle |
| iss_kind_o | output | 3 | Kind of the issued operation |
| iss_tag_o | output | 3 | Tag of the issued operation |
| cmp_valid_i | input | 1 | Memory completion present |
| cmp_tag_i | input | 3 | Tag of the completed operation |
| busy_o | output | 1 | An ordering barrier is draining |
| fence_retire_o | output | 1 | A pending fence retires this cycle |

## Verification
The hardest situations to reach are those where a stalled token is released by one specific completion. Examples are the ninth load that waits for a single freed tag, a load held behind an acquire while older loads are still outstanding, and a release held until the last older store finishes. The stimulus reaches them by forking the token driver against a completion driver. The driver keeps the stalled token on the port while the completion branch first samples `op_ready_o` and `busy_o`, then returns one chosen tag. The scoreboard then expects the waiting token to issue with exactly the tag that was freed.

// File: rtl/mo_pkg.sv
package mo_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_FENCE = 3'd2,
    OP_ACQ   = 3'd3,
    OP_REL   = 3'd4
  } op_kind_e;

  typedef enum logic [1:0] {
    MODE_SEQ  = 2'd0,
    MODE_WEAK = 2'd1,
    MODE_REL  = 2'd2
  } ord_mode_e;
endpackage

// File: rtl/mo_tag_tracker.sv
module mo_tag_tracker #(
  parameter int TAG_W = 3,
  localparam int NTAG = 1 << TAG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] clr_tag_i,
  output logic [NTAG-1:0]  out_vec_o,
  output logic [TAG_W-1:0] free_tag_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [NTAG-1:0] out_q, set_vec, clr_vec;

  generate
    for (genvar g = 0; g < NTAG; g++) begin : g_bit
      assign set_vec[g] = set_i && (set_tag_i == TAG_W'(g));
      assign clr_vec[g] = clr_i && (clr_tag_i == TAG_W'(g));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= (out_q & ~clr_vec) | set_vec;
  end

  // lowest free tag wins
  always_comb begin
    free_tag_o = '0;
    for (int i = NTAG - 1; i >= 0; i--)
      if (!out_q[i]) free_tag_o = TAG_W'(i);
  end

  assign full_o    = &out_q;
  assign empty_o   = ~|out_q;
  assign out_vec_o = out_q;
endmodule

// File: rtl/mo_barrier_ctrl.sv
module mo_barrier_ctrl #(
  parameter int TAG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fence_acc_i,
  input  logic             empty_i,
  input  logic             bar_set_i,
  input  logic [TAG_W-1:0] bar_tag_i,
  input  logic             cmp_valid_i,
  input  logic [TAG_W-1:0] cmp_tag_i,
  output logic             fence_pend_o,
  output logic             fence_retire_o,
  output logic             bar_live_o
);
  logic             fence_pend_q, bar_live_q;
  logic [TAG_W-1:0] bar_tag_q;

  assign fence_retire_o = fence_pend_q && empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fence_pend_q <= 1'b0;
      bar_live_q   <= 1'b0;
      bar_tag_q    <= '0;
    end else begin
      if (fence_acc_i)         fence_pend_q <= 1'b1;
      else if (fence_retire_o) fence_pend_q <= 1'b0;
      if (bar_set_i) begin
        bar_live_q <= 1'b1;
        bar_tag_q  <= bar_tag_i;
      end else if (bar_live_q && cmp_valid_i && cmp_tag_i == bar_tag_q) begin
        bar_live_q <= 1'b0;
      end
    end
  end

  assign fence_pend_o = fence_pend_q;
  assign bar_live_o   = bar_live_q;
endmodule

// File: rtl/mo_order_gate.sv
module mo_order_gate
  import mo_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [2:0] kind_i,
  input  logic       fence_pend_i,
  input  logic       bar_live_i,
  input  logic       full_i,
  input  logic       empty_i,
  output logic       ok_o,
  output logic       bar_set_kind_o
);
  logic rule_ok;

  always_comb begin
    rule_ok        = 1'b0;
    bar_set_kind_o = 1'b0;
    unique case (mode_i)
      MODE_WEAK: begin
        unique case (kind_i)
          OP_LOAD, OP_STORE: rule_ok = !full_i;
          OP_FENCE:          rule_ok = 1'b1;
          OP_ACQ, OP_REL: begin
            rule_ok        = empty_i;
            bar_set_kind_o = 1'b1;
          end
          default:           rule_ok = 1'b0;
        endcase
      end
      MODE_REL: begin
        unique case (kind_i)
          OP_LOAD, OP_STORE: rule_ok = !full_i;
          OP_FENCE:          rule_ok = 1'b1;
          OP_ACQ: begin
            rule_ok        = !full_i;
            bar_set_kind_o = 1'b1;
          end
          OP_REL:            rule_ok = empty_i;
          default:           rule_ok = 1'b0;
        endcase
      end
      default: rule_ok = empty_i && (kind_i <= OP_REL);
    endcase
  end

  assign ok_o = rule_ok && !fence_pend_i && !bar_live_i;
endmodule

// File: rtl/mem_order_issue.sv
module mem_order_issue
  import mo_pkg::*;
#(
  parameter int TAG_W = 3,
  localparam int NTAG = 1 << TAG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             op_valid_i,
  input  logic [2:0]       op_kind_i,
  output logic             op_ready_o,
  output logic             iss_valid_o,
  output logic [2:0]       iss_kind_o,
  output logic [TAG_W-1:0] iss_tag_o,
  input  logic             cmp_valid_i,
  input  logic [TAG_W-1:0] cmp_tag_i,
  output logic             busy_o,
  output logic             fence_retire_o
);
  logic [NTAG-1:0]  out_vec;
  logic [TAG_W-1:0] free_tag;
  logic full, empty, fence_pend, bar_live, gate_ok, bar_kind;
  logic accept, fence_acc, bar_set;

  assign accept      = op_valid_i && gate_ok;
  assign fence_acc   = accept && op_kind_i == OP_FENCE;
  assign iss_valid_o = accept && op_kind_i != OP_FENCE;
  assign bar_set     = iss_valid_o && bar_kind;
  assign iss_kind_o  = op_kind_i;
  assign iss_tag_o   = free_tag;
  assign op_ready_o  = gate_ok;
  assign busy_o      = fence_pend || bar_live ||
                       (op_valid_i && op_kind_i == OP_REL && !empty);

  mo_tag_tracker #(.TAG_W(TAG_W)) u_trk (
    .clk_i, .rst_ni,
    .set_i      (iss_valid_o),
    .set_tag_i  (free_tag),
    .clr_i      (cmp_valid_i),
    .clr_tag_i  (cmp_tag_i),
    .out_vec_o  (out_vec),
    .free_tag_o (free_tag),
    .full_o     (full),
    .empty_o    (empty)
  );

  mo_barrier_ctrl #(.TAG_W(TAG_W)) u_bar (
    .clk_i, .rst_ni,
    .fence_acc_i    (fence_acc),
    .empty_i        (empty),
    .bar_set_i      (bar_set),
    .bar_tag_i      (free_tag),
    .cmp_valid_i    (cmp_valid_i),
    .cmp_tag_i      (cmp_tag_i),
    .fence_pend_o   (fence_pend),
    .fence_retire_o (fence_retire_o),
    .bar_live_o     (bar_live)
  );

  mo_order_gate u_gate (
    .mode_i         (mode_i),
    .kind_i         (op_kind_i),
    .fence_pend_i   (fence_pend),
    .bar_live_i     (bar_live),
    .full_i         (full),
    .empty_i        (empty),
    .ok_o           (gate_ok),
    .bar_set_kind_o (bar_kind)
  );
endmodule

// File: rtl/mem_order_issue_chk.sv
module mem_order_issue_chk #(
  parameter int TAG_W = 3,
  localparam int NTAG = 1 << TAG_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             op_valid_i,
  input logic [2:0]       op_kind_i,
  input logic             op_ready_o,
  input logic             iss_valid_o,
  input logic [2:0]       iss_kind_o,
  input logic [TAG_W-1:0] iss_tag_o,
  input logic             fence_retire_o,
  input logic [NTAG-1:0]  out_vec
);
  p_seq_serial_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && iss_valid_o) |=> (mode_i != 2'd0 || !iss_valid_o));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_o |-> !out_vec[iss_tag_o]);

  p_fence_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_ready_o && op_kind_i == 3'd2) |=> !op_ready_o);

  p_retire_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_retire_o |=> !fence_retire_o);

  p_acq_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_kind_o == 3'd3 && mode_i == 2'd2) |=> !iss_valid_o);

  p_rel_drain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && iss_kind_o == 3'd4) |-> out_vec == '0);
endmodule

bind mem_order_issue mem_order_issue_chk #(.TAG_W(TAG_W)) u_chk (
  .clk_i, .rst_ni, .mode_i, .op_valid_i, .op_kind_i, .op_ready_o,
  .iss_valid_o, .iss_kind_o, .iss_tag_o, .fence_retire_o,
  .out_vec (out_vec)
);

// File: tb/mem_order_issue_tb_top.sv
module mem_order_issue_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd1;
  logic       op_valid_i = 1'b0;
  logic [2:0] op_kind_i = 3'd0;
  logic       op_ready_o, iss_valid_o, busy_o, fence_retire_o;
  logic [2:0] iss_kind_o, iss_tag_o;
  logic       cmp_valid_i = 1'b0;
  logic [2:0] cmp_tag_i = 3'd0;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] model_out = '0;
  logic [2:0] exp_kind_q[$], exp_tag_q[$];
  string      exp_req_q[$];

  always #10 clk_i = ~clk_i;

  mem_order_issue dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] low_free();
    for (int i = 0; i < 8; i++) if (!model_out[i]) return 3'(i);
    return 3'd0;
  endfunction

  // starts and ends at a falling edge
  task automatic send(input logic [2:0] kind, input string req);
    op_valid_i = 1'b1;
    op_kind_i  = kind;
    forever begin
      #1;
      if (op_ready_o) break;
      @(negedge clk_i);
    end
    if (kind != 3'd2) begin
      exp_kind_q.push_back(kind);
      exp_tag_q.push_back(low_free());
      exp_req_q.push_back(req);
      model_out[low_free()] = 1'b1;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    op_valid_i = 1'b0;
  endtask

  task automatic cmp(input logic [2:0] tag);
    cmp_valid_i = 1'b1;
    cmp_tag_i   = tag;
    @(posedge clk_i);
    model_out[tag] = 1'b0;
    @(negedge clk_i);
    cmp_valid_i = 1'b0;
  endtask

  // scoreboard monitor
  always begin
    @(negedge clk_i);
    #5;
    if (iss_valid_o) begin
      if (exp_kind_q.size() == 0) begin
        chk(0, "R9 unexpected issue", int'(iss_tag_o), -1);
      end else begin
        automatic logic [2:0] ek = exp_kind_q.pop_front();
        automatic logic [2:0] et = exp_tag_q.pop_front();
        automatic string      er = exp_req_q.pop_front();
        chk(iss_kind_o == ek, {er, " kind"}, int'(iss_kind_o), int'(ek));
        chk(iss_tag_o == et, {er, " tag"}, int'(iss_tag_o), int'(et));
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      chk(0, "watchdog", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && iss_valid_o == 0 && fence_retire_o == 0, "R1 reset outputs",
        int'({busy_o, iss_valid_o, fence_retire_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // weak: stream 8, ninth waits
    mode_i = 2'd1;
    send(3'd0, "R1");
    for (int i = 1; i < 8; i++) send(3'(i % 2), "R3");
    fork
      send(3'd1, "R3 freed tag");
      begin
        repeat (2) @(negedge clk_i);
        #2 chk(op_ready_o == 0, "R3 ninth stalls", int'(op_ready_o), 0);
        @(negedge clk_i);
        cmp(3'd5);
      end
    join
    for (int i = 0; i < 8; i++) cmp(3'(i));

    // fence with outstanding ops
    send(3'd0, "R4");
    send(3'd0, "R4");
    send(3'd2, "R4");
    op_valid_i = 1'b1; op_kind_i = 3'd0;
    #1 chk(op_ready_o == 0, "R4 fence blocks", int'(op_ready_o), 0);
    chk(busy_o == 1, "R5 busy on fence", int'(busy_o), 1);
    @(negedge clk_i);
    op_valid_i = 1'b0;
    cmp(3'd0);
    #1 chk(fence_retire_o == 0, "R4 no early retire", int'(fence_retire_o), 0);
    @(negedge clk_i);
    cmp(3'd1);
    #1 chk(fence_retire_o == 1, "R4 retire when empty", int'(fence_retire_o), 1);
    @(negedge clk_i);
    #1 chk(fence_retire_o == 0 && busy_o == 0, "R4 single retire pulse",
           int'({fence_retire_o, busy_o}), 0);
    @(negedge clk_i);

    // fence with nothing outstanding
    send(3'd2, "R4");
    #1 chk(fence_retire_o == 1, "R4 empty fence retires next cycle", int'(fence_retire_o), 1);
    @(negedge clk_i);

    // sequential
    mode_i = 2'd0;
    send(3'd0, "R2");
    fork
      send(3'd1, "R2 after completion");
      begin
        repeat (2) @(negedge clk_i);
        #2 chk(op_ready_o == 0, "R2 serial stall", int'(op_ready_o), 0);
        @(negedge clk_i);
        cmp(3'd0);
      end
    join
    cmp(3'd0);

    // release mode: acquire
    mode_i = 2'd2;
    send(3'd0, "R6");
    send(3'd0, "R6");
    send(3'd3, "R6 acquire skips drain");
    fork
      send(3'd0, "R6 after acquire");
      begin
        @(negedge clk_i);
        #2 chk(op_ready_o == 0, "R6 acquire blocks", int'(op_ready_o), 0);
        chk(busy_o == 1, "R5 busy on acquire", int'(busy_o), 1);
        @(negedge clk_i);
        cmp(3'd2);
      end
    join
    cmp(3'd0); cmp(3'd1); cmp(3'd2);

    // release mode: release
    send(3'd1, "R7");
    fork
      send(3'd4, "R7 release after drain");
      begin
        @(negedge clk_i);
        #2 chk(op_ready_o == 0 && busy_o == 1, "R7 release waits, R5 busy",
               int'({op_ready_o, busy_o}), 1);
        @(negedge clk_i);
        cmp(3'd0);
      end
    join
    op_valid_i = 1'b1; op_kind_i = 3'd0;
    #1 chk(op_ready_o == 1, "R7 later load passes release", int'(op_ready_o), 1);
    op_valid_i = 1'b0;
    send(3'd0, "R7 later load");
    cmp(3'd0); cmp(3'd1);

    // weak: acquire as full barrier
    mode_i = 2'd1;
    send(3'd0, "R8");
    fork
      send(3'd3, "R8 acquire waits drain");
      begin
        @(negedge clk_i);
        #2 chk(op_ready_o == 0, "R8 acquire stalls", int'(op_ready_o), 0);
        @(negedge clk_i);
        cmp(3'd0);
      end
    join
    fork
      send(3'd1, "R8 after barrier");
      begin
        @(negedge clk_i);
        #2 chk(op_ready_o == 0, "R8 barrier blocks", int'(op_ready_o), 0);
        @(negedge clk_i);
        cmp(3'd0);
      end
    join
    cmp(3'd0);

    // stray completion
    send(3'd0, "R9");
    cmp(3'd5);
    send(3'd0, "R9 stray completion ignored");
    cmp(3'd0); cmp(3'd1);
    repeat (3) @(negedge clk_i);
    chk(exp_kind_q.size() == 0, "R9 all expected issued", exp_kind_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule